// File: doc/BRIEF.md
# Asynchronous PSRAM access controller

This block sits between a synchronous host and an asynchronous pseudo-static RAM with 524,288 words of 16 bits. The host raises a one-cycle request with a write flag, a 19-bit word address, write data and two byte-enable bits. The controller then runs the memory's control pins through a fixed sequence of clock cycles. It reports completion with a one-cycle done pulse. For reads it presents the returned word on a host register.

Every read is controlled by chip enable. The address and byte enables are placed on the pins one cycle before chip enable falls, and they stay unchanged until chip enable rises again. A write ends when write enable rises, which happens one cycle before chip enable rises. The write data stays on the bus for that extra cycle, so hold time is measured from the edge that actually ends the write. Cycle counts come from nanosecond parameters divided by the clock period and rounded up. At the defaults (4 ns clock, 55 ns access, 45 ns write pulse) this gives 14 read cycles and 12 write cycles. All memory-side pins come straight from flip-flops.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, all five active-low memory controls are high, the bus is not driven, host_ready is 1 and host_done is 0.
- R2: The address is latched when a request is accepted. It is on mem_addr during the setup cycle (chip enable high) and stays unchanged for every cycle chip enable is low, whatever host_addr does meanwhile.
- R3: A read holds chip enable and output enable low with write enable high for ceil(ACCESS_NS/CLK_NS) cycles (14 at defaults). The bus is sampled in the last of those cycles and shows on host_rdata in the done cycle. A lane whose host_be bit is 0 reads as zero.
- R4: A write holds chip enable and write enable low for ceil(WPULSE_NS/CLK_NS) cycles (12 at defaults), with output enable high and mem_dq_out equal to host_wdata. Write enable then rises while chip enable stays low and the bus stays driven for one more cycle.
- R5: host_be bit 0 selects data bits 7:0 through mem_lb_n, and bit 1 selects bits 15:8 through mem_ub_n. Each pin is low exactly while chip enable is low and its host bit is 1.
- R6: mem_dq_oe is never 1 while output enable is low. Output enable is never low while write enable is low.
- R7: host_done is a one-cycle pulse, and chip enable is high in the done cycle. host_ready is low from acceptance until the cycle after done. Requests made while host_ready is low are ignored.
- R8: A request with host_be = 2'b00 raises host_done in the cycle after acceptance, never lowers chip enable, and leaves memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request, taken when host_ready is 1 |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables, bit0 low byte, bit1 high byte |
| host_ready | output | 1 | Controller idle, request accepted |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data from the last read |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_in | input | 16 | Data returned by the memory |
| mem_dq_oe | output | 1 | Bus drive enable |

## Verification
The sequencer state is decoded straight into registered pins, so a wrong state shows up on the control pins in the same cycle it arises. Typical signs are a pulse one cycle too long or too short, write enable rising together with chip enable, or output enable falling while the bus is still driven. A wrong access counter shows up on host_rdata in the done cycle. The memory model puts garbage on the bus until the full access time has elapsed, so sampling one cycle early corrupts the read data. A wrong lane latch shows up in the byte enables from the first cycle chip enable is low, and later as read-back that does not match the masked scoreboard.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_READ,
        ST_WRITE,
        ST_WHOLD,
        ST_RECOVER
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
        logic lanes_on;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                        drive: 1'b0, lanes_on: 1'b0};

    function automatic int unsigned cycles_for(input int unsigned ns,
                                               input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_timer.sv
module psram_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/psram_seq.sv
module psram_seq
    import psram_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       new_null,
    input  logic       cur_wr,
    input  logic       tmr_last,
    output seq_state_e st_q,
    output seq_state_e st_d,
    output logic       accept
);
    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    st_d   = new_null ? ST_RECOVER : ST_SETUP;
                end
            end
            ST_SETUP:   st_d = cur_wr ? ST_WRITE : ST_READ;
            ST_READ:    if (tmr_last) st_d = ST_RECOVER;
            ST_WRITE:   if (tmr_last) st_d = ST_WHOLD;
            ST_WHOLD:   st_d = ST_RECOVER;
            ST_RECOVER: st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/psram_pin_decode.sv
module psram_pin_decode
    import psram_pkg::*;
(
    input  seq_state_e st,
    input  logic [1:0] be,
    output pin_ctl_t   ctl,
    output logic [1:0] lane_n
);
    always_comb begin
        ctl = PINS_QUIET;
        case (st)
            ST_READ: begin
                ctl.ce_n     = 1'b0;
                ctl.oe_n     = 1'b0;
                ctl.lanes_on = 1'b1;
            end
            ST_WRITE: begin
                ctl.ce_n     = 1'b0;
                ctl.we_n     = 1'b0;
                ctl.drive    = 1'b1;
                ctl.lanes_on = 1'b1;
            end
            ST_WHOLD: begin
                ctl.ce_n     = 1'b0;
                ctl.drive    = 1'b1;
                ctl.lanes_on = 1'b1;
            end
            default: ctl = PINS_QUIET;
        endcase
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lane_n[g] = ~(ctl.lanes_on & be[g]);
    end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CLK_NS    = 4,
    parameter int unsigned ACCESS_NS = 55,
    parameter int unsigned WPULSE_NS = 45
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [1:0]        host_be,
    output logic              host_ready,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int unsigned RD_CYC = cycles_for(ACCESS_NS, CLK_NS);
    localparam int unsigned WR_CYC = cycles_for(WPULSE_NS, CLK_NS);
    localparam int unsigned TMR_W  = $clog2(max_u(RD_CYC, WR_CYC)) + 1;
    localparam int unsigned LANE_W = DATA_W / 2;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [1:0]        be;
    } cmd_t;

    cmd_t       cmd_q, cmd_d;
    seq_state_e st_q, st_d;
    logic       accept, tmr_last, tmr_load, capture;
    logic [TMR_W-1:0] tmr_val;
    pin_ctl_t   ctl_d;
    logic [1:0] lane_n_d;
    logic [DATA_W-1:0] rdata_q;
    logic       done_q;

    psram_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (host_req),
        .new_null (host_be == 2'b00),
        .cur_wr   (cmd_q.wr),
        .tmr_last (tmr_last),
        .st_q     (st_q),
        .st_d     (st_d),
        .accept   (accept)
    );

    assign tmr_load = (st_q == ST_SETUP);
    assign tmr_val  = cmd_q.wr ? TMR_W'(WR_CYC - 1) : TMR_W'(RD_CYC - 1);

    psram_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    always_comb begin
        cmd_d = cmd_q;
        if (accept) begin
            cmd_d.wr   = host_wr;
            cmd_d.addr = host_addr;
            cmd_d.data = host_wdata;
            cmd_d.be   = host_be;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= cmd_d;
    end

    psram_pin_decode u_dec (
        .st     (st_d),
        .be     (cmd_d.be),
        .ctl    (ctl_d),
        .lane_n (lane_n_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            mem_ce_n  <= ctl_d.ce_n;
            mem_oe_n  <= ctl_d.oe_n;
            mem_we_n  <= ctl_d.we_n;
            mem_ub_n  <= lane_n_d[1];
            mem_lb_n  <= lane_n_d[0];
            mem_dq_oe <= ctl_d.drive;
            done_q    <= (st_d == ST_RECOVER);
        end
    end

    assign capture = (st_q == ST_READ) && tmr_last;

    for (genvar g = 0; g < 2; g++) begin : g_rlane
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata_q[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rdata_q[g*LANE_W +: LANE_W] <= cmd_q.be[g] ? mem_dq_in[g*LANE_W +: LANE_W]
                                                          : '0;
            end
        end
    end

    assign host_ready = (st_q == ST_IDLE);
    assign host_done  = done_q;
    assign host_rdata = rdata_q;
    assign mem_addr   = cmd_q.addr;
    assign mem_dq_out = cmd_q.data;
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
    parameter int unsigned ADDR_W = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              host_ready,
    input logic              host_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_ub_n,
    input logic              mem_lb_n,
    input logic              mem_dq_oe
);
    // R2: address steady while chip enable is low, and set up before it falls
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
    p_addr_setup_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |-> $stable(mem_addr));

    // R4: write enable is high in the cycle before chip enable rises
    p_we_first_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ce_n) |-> $past(mem_we_n));
    p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));

    // R5: an active access always has at least one lane selected
    p_lane_sel_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> !(mem_ub_n && mem_lb_n));
    p_lane_idle_r5: assert property (@(posedge clk) disable iff (rst)
        mem_ce_n |-> (mem_ub_n && mem_lb_n));

    // R6: no bus fight and no read during write
    p_no_fight_r6: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);
    p_oe_we_r6: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> mem_we_n);

    // R7: done pulse shape and idle pins
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        host_done |=> !host_done);
    p_done_ce_r7: assert property (@(posedge clk) disable iff (rst)
        host_done |-> (mem_ce_n && !host_ready));
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> (mem_ce_n && !mem_dq_oe));
endmodule

bind psram_ctrl psram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_psram_ctrl.sv
module test_psram_ctrl;
    localparam int RD = 14;  // ceil(55/4)
    localparam int WR = 12;  // ceil(45/4)

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [18:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_be = '0;
    logic        host_ready, host_done;
    logic [15:0] host_rdata;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hBAD0;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    psram_ctrl i_psram_ctrl (
        .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // behavioural memory: word array, per-lane writes, delayed read data
    logic [15:0] mem_a [int];
    logic [15:0] sb [int];
    int  rd_run = 0;
    int  we_run = 0;
    bit  we_low_seen = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            rd_run = 0; we_run = 0; we_low_seen = 1'b0;
        end else begin
            if (!mem_ce_n && !mem_oe_n) rd_run++;
            else rd_run = 0;
            if (!mem_ce_n && !mem_we_n) begin
                chk("R4", "bus driven in write pulse", mem_dq_oe, 1);
                if (!mem_a.exists(int'(mem_addr))) mem_a[int'(mem_addr)] = 16'h0000;
                if (!mem_lb_n) mem_a[int'(mem_addr)][7:0]  = mem_dq_out[7:0];
                if (!mem_ub_n) mem_a[int'(mem_addr)][15:8] = mem_dq_out[15:8];
                we_run++;
                we_low_seen = 1'b1;
            end else if (we_low_seen) begin
                chk("R4", "write pulse length", we_run, WR);
                chk("R4", "ce low and data held after we rises",
                    {31'd0, !mem_ce_n && mem_dq_oe}, 1);
                we_run = 0;
                we_low_seen = 1'b0;
            end
            if (!mem_ce_n && !mem_oe_n && rd_run >= RD) begin
                logic [15:0] w;
                w = mem_a.exists(int'(mem_addr)) ? mem_a[int'(mem_addr)] : 16'h0000;
                mem_dq_in = {mem_ub_n ? 8'hA5 : w[15:8], mem_lb_n ? 8'hA5 : w[7:0]};
            end else begin
                mem_dq_in = 16'hBAD0;
            end
        end
    end

    function automatic logic [15:0] sb_rd(input logic [18:0] a);
        return sb.exists(int'(a)) ? sb[int'(a)] : 16'h0000;
    endfunction

    task automatic run_op(input bit wr, input logic [18:0] a, input logic [15:0] d,
                          input logic [1:0] b, input bit hold);
        int total;
        string rq;
        logic [15:0] exp_rd;
        @(negedge clk);
        chk("R7", "ready before request", host_ready, 1);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d; host_be = b;
        total = (b == 2'b00) ? 2 : (wr ? WR + 4 : RD + 3);
        rq    = (b == 2'b00) ? "R8" : (wr ? "R4" : "R3");
        exp_rd = sb_rd(a) & {{8{b[1]}}, {8{b[0]}}};
        for (int i = 1; i <= total; i++) begin
            logic ce, oe, we, drv, rdy, dn, act;
            @(negedge clk);
            ce = 1; oe = 1; we = 1; drv = 0; rdy = 0; dn = 0; act = 0;
            if (b == 2'b00) begin
                dn  = (i == 1);
                rdy = (i == 2);
            end else if (!wr) begin
                if (i >= 2 && i <= RD + 1) begin ce = 0; oe = 0; act = 1; end
                dn  = (i == RD + 2);
                rdy = (i == RD + 3);
            end else begin
                if (i >= 2 && i <= WR + 1) begin ce = 0; we = 0; drv = 1; act = 1; end
                if (i == WR + 2) begin ce = 0; drv = 1; act = 1; end
                dn  = (i == WR + 3);
                rdy = (i == WR + 4);
            end
            chk(rq, $sformatf("ctl {ce,oe,we,oe_bus} cycle %0d", i),
                {28'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, {28'd0, ce, oe, we, drv});
            chk("R7", $sformatf("ready/done cycle %0d", i),
                {30'd0, host_ready, host_done}, {30'd0, rdy, dn});
            chk("R5", $sformatf("byte enables {ub,lb} cycle %0d", i),
                {30'd0, mem_ub_n, mem_lb_n},
                {30'd0, !(act && b[1]), !(act && b[0])});
            if (b != 2'b00 && i <= total - 2)
                chk("R2", $sformatf("address cycle %0d", i), mem_addr, a);
            if (drv) chk("R4", "write data on bus", mem_dq_out, d);
            if (dn && !wr && b != 2'b00) chk("R3", "read data", host_rdata, exp_rd);
            if (hold && i > 1) begin
                host_addr = ~a; host_wdata = ~d; host_be = 2'b11; host_wr = ~wr;
            end
            if (!hold || dn) host_req = 1'b0;
        end
        if (hold) begin
            @(negedge clk);
            chk("R7", "no access from request held while busy", mem_ce_n, 1);
        end
        if (wr && b != 2'b00) begin
            logic [15:0] w;
            w = sb_rd(a);
            if (b[0]) w[7:0]  = d[7:0];
            if (b[1]) w[15:8] = d[15:8];
            sb[int'(a)] = w;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset controls {ce,oe,we,ub,lb,bus}",
            {26'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe},
            {26'd0, 6'b111110});
        chk("R1", "reset ready/done", {30'd0, host_ready, host_done}, 32'd2);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "after reset controls",
            {26'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe},
            {26'd0, 6'b111110});

        run_op(1, 19'h00123, 16'h1234, 2'b11, 0);
        run_op(0, 19'h00123, 16'h0000, 2'b11, 0);
        run_op(1, 19'h00123, 16'hABCD, 2'b10, 0);  // upper lane only
        run_op(0, 19'h00123, 16'h0000, 2'b01, 0);  // expect 0034
        run_op(0, 19'h00123, 16'h0000, 2'b10, 0);  // expect AB00
        run_op(1, 19'h00123, 16'hFFFF, 2'b00, 0);  // null write, R8
        run_op(0, 19'h00123, 16'h0000, 2'b11, 0);  // still AB34
        run_op(1, 19'h7FFFF, 16'h5AA5, 2'b11, 0);
        run_op(1, 19'h00000, 16'hC3C3, 2'b01, 1);  // held request, R7
        run_op(0, 19'h7FFFF, 16'h0000, 2'b11, 1);
        run_op(0, 19'h00000, 16'h0000, 2'b11, 0);
        run_op(0, 19'h00005, 16'h0000, 2'b00, 1);  // null read
        chk("R8", "memory word unchanged by null write",
            mem_a.exists(32'h123) ? {16'd0, mem_a[32'h123]} : 32'hFFFF_FFFF, 32'h0000AB34);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule